// File: doc/BRIEF.md
# Upconverter Configuration Register and Sync Controller

This block is the host-side control front end of a digital upconverter. A host drives a 10-bit address and a 16-bit data word and raises an asynchronous write strobe. The block brings the strobe into the master clock domain and decodes the write. It then updates the modulation mode, output gain, sync polarity and timing-rate registers. Writes that fall in the upper half of the address space are passed on to the shaping-filter coefficient storage as one-clock write pulses.

The block also decides when the datapath may run. After a pin reset, or after a write to the soft-reset address, the run enable is held low until a sync event arrives. A sync event is either an edge on the external sync pin, with the active edge chosen by a polarity bit, or a write to the low half of the timing-rate word. Each sync event is repeated on a one-clock output pulse, so that slave devices can be started in step with this one.

Top module: `cfg_sync_ctrl`

## Requirements
- R1: While `rst_ni` is low and right after it rises, `run_o`, `sync_o` and `coef_we_o` are 0. `mode_o`, `gain_o` and `timing_word_o` are 0, and the sync polarity is 0 (rising edge).
- R2: A write takes effect only if `ce_i` is 1 when the strobe rise is detected. If `ce_i` is 0, no register changes and no coefficient pulse is produced.
- R3: A write to address 16 loads `mode_o` from data bits 1:0. The codes are 00 vector, 01 FM filtered after modulation, and 10 FM with pulse shaping before modulation. A write of code 11 leaves `mode_o` unchanged.
- R4: A write to address 17 loads `gain_o` from data bits 7:0.
- R5: After any reset, `run_o` stays 0 until a sync event occurs, even when other registers are written.
- R6: Bit 0 of address 22 selects the sync pin edge. With 0, a low-to-high transition of `sync_i` is a sync event. With 1, a high-to-low transition is a sync event. The opposite edge has no effect.
- R7: A write to address 2 loads `timing_word_o[15:0]` and is a sync event. A write to address 3 loads `timing_word_o[31:16]` and is not a sync event.
- R8: Every sync event sets `run_o` and produces exactly one `sync_o` pulse, one clock wide, on the clock edge after the event.
- R9: A write to address 21 returns mode, gain, polarity and timing word to 0 and drops `run_o`, just as the reset pin does.
- R10: A write to any address from 512 to 1023 gives a one-clock `coef_we_o` pulse. `coef_addr_o` carries address minus 512 and `coef_data_o` carries the data. No control register changes.
- R11: The strobe and the sync pin each pass through two synchronizer flops before edge detection. A register write is visible on the third rising clock edge at which the strobe is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Asynchronous write strobe, active on its rising edge |
| ce_i | input | 1 | Chip enable, qualifies the write |
| addr_i | input | 10 | Write address |
| data_i | input | 16 | Write data |
| sync_i | input | 1 | External sync pin, asynchronous |
| mode_o | output | 2 | Modulation mode |
| gain_o | output | 8 | Output gain |
| timing_word_o | output | 32 | Timing-rate control word |
| run_o | output | 1 | Datapath run enable |
| sync_o | output | 1 | One-clock sync pulse for slave devices |
| coef_we_o | output | 1 | Coefficient write pulse |
| coef_addr_o | output | 9 | Coefficient index |
| coef_data_o | output | 16 | Coefficient data |

## Verification
The assertions watch several rules on every cycle:
- the mode register never holds the unused code;
- a soft reset always clears the registers and the run enable on the next edge;
- a write without chip enable changes nothing;
- every sync event is followed by a sync pulse, and every pulse has such a cause;
- the run enable rises only after a sync event;
- coefficient pulses are one clock wide.

Other behaviours can only be shown by the bench's scenarios. These are the exact three-edge write latency, the choice of active pin edge under each polarity, the address and data values forwarded to the coefficient store, and the fact that the high timing word does not start the datapath.

// File: rtl/cfg_sync_pkg.sv
`timescale 1ns/1ps
package cfg_sync_pkg;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned GAIN_W = 8;

  typedef enum logic [1:0] {
    MOD_VECTOR  = 2'b00,
    MOD_FM_POST = 2'b01,
    MOD_FM_PRE  = 2'b10
  } mod_sel_e;

  localparam logic [ADDR_W-1:0] A_TIME_LO = 10'd2;
  localparam logic [ADDR_W-1:0] A_TIME_HI = 10'd3;
  localparam logic [ADDR_W-1:0] A_MODE    = 10'd16;
  localparam logic [ADDR_W-1:0] A_GAIN    = 10'd17;
  localparam logic [ADDR_W-1:0] A_SOFTRST = 10'd21;
  localparam logic [ADDR_W-1:0] A_SYNCCFG = 10'd22;
endpackage

// File: rtl/cfg_edge_sync.sv
`timescale 1ns/1ps
module cfg_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic [STAGES-1:0] stage_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stage_q[g] <= 1'b0;
          else         stage_q[g] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stage_q[g] <= 1'b0;
          else         stage_q[g] <= stage_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= stage_q[STAGES-1];

  // edge seen on the synchronized level only
  assign edge_o = fall_sel_i ? (prev_q & ~stage_q[STAGES-1])
                             : (~prev_q & stage_q[STAGES-1]);
endmodule

// File: rtl/cfg_reg_file.sv
`timescale 1ns/1ps
module cfg_reg_file
  import cfg_sync_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned GW = GAIN_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_evt_i,
  input  logic            ce_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   data_i,
  output logic            soft_rst_o,
  output logic            time_lo_wr_o,
  output logic [1:0]      mode_o,
  output logic [GW-1:0]   gain_o,
  output logic            pol_o,
  output logic [2*DW-1:0] timing_word_o,
  output logic            coef_we_o,
  output logic [AW-2:0]   coef_addr_o,
  output logic [DW-1:0]   coef_data_o
);
  logic            hit;
  logic            coef_hit;
  logic            mode_ok;
  logic [1:0]      mode_q;
  logic [GW-1:0]   gain_q;
  logic            pol_q;
  logic [2*DW-1:0] tword_q;

  assign hit          = wr_evt_i & ce_i;
  assign coef_hit     = hit & addr_i[AW-1];
  assign soft_rst_o   = hit & (addr_i == A_SOFTRST);
  assign time_lo_wr_o = hit & (addr_i == A_TIME_LO);
  assign mode_ok      = (data_i[1:0] == MOD_VECTOR) || (data_i[1:0] == MOD_FM_POST)
                     || (data_i[1:0] == MOD_FM_PRE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      gain_q  <= '0;
      pol_q   <= 1'b0;
      tword_q <= '0;
    end else if (soft_rst_o) begin
      mode_q  <= '0;
      gain_q  <= '0;
      pol_q   <= 1'b0;
      tword_q <= '0;
    end else if (hit && !addr_i[AW-1]) begin
      unique case (addr_i)
        A_MODE:    if (mode_ok) mode_q <= data_i[1:0];
        A_GAIN:    gain_q <= data_i[GW-1:0];
        A_SYNCCFG: pol_q  <= data_i[0];
        A_TIME_LO: tword_q[DW-1:0]    <= data_i;
        A_TIME_HI: tword_q[2*DW-1:DW] <= data_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coef_we_o   <= 1'b0;
      coef_addr_o <= '0;
      coef_data_o <= '0;
    end else begin
      coef_we_o <= coef_hit;
      if (coef_hit) begin
        coef_addr_o <= addr_i[AW-2:0];
        coef_data_o <= data_i;
      end
    end
  end

  assign mode_o        = mode_q;
  assign gain_o        = gain_q;
  assign pol_o         = pol_q;
  assign timing_word_o = tword_q;

  p_mode_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != 2'b11);
  p_soft_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> (mode_q == '0 && gain_q == '0 && tword_q == '0 && !pol_q));
  p_ce_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_evt_i && !ce_i) |=> ($stable(mode_q) && $stable(gain_q) && $stable(tword_q) && !coef_we_o));
  p_coef_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_we_o |=> !coef_we_o);
endmodule

// File: rtl/cfg_sync_gen.sv
`timescale 1ns/1ps
module cfg_sync_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic pin_edge_i,
  input  logic wr_sync_i,
  output logic run_o,
  output logic sync_o
);
  logic sync_evt;
  logic run_q;
  logic sync_q;

  // reset write wins over a coincident pin edge
  assign sync_evt = (pin_edge_i | wr_sync_i) & ~soft_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      sync_q <= sync_evt;
      if (soft_rst_i)    run_q <= 1'b0;
      else if (sync_evt) run_q <= 1'b1;
    end
  end

  assign run_o  = run_q;
  assign sync_o = sync_q;

  p_sync_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_evt |=> (sync_o && run_o));
  p_sync_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> $past(sync_evt));
  p_run_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> $past(sync_evt));
  p_soft_halt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !run_o);
endmodule

// File: rtl/cfg_sync_ctrl.sv
`timescale 1ns/1ps
module cfg_sync_ctrl
  import cfg_sync_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic                ce_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic                sync_i,
  output logic [1:0]          mode_o,
  output logic [GAIN_W-1:0]   gain_o,
  output logic [2*DATA_W-1:0] timing_word_o,
  output logic                run_o,
  output logic                sync_o,
  output logic                coef_we_o,
  output logic [ADDR_W-2:0]   coef_addr_o,
  output logic [DATA_W-1:0]   coef_data_o
);
  logic wr_evt;
  logic pin_evt;
  logic pol;
  logic soft_rst;
  logic time_lo_wr;

  cfg_edge_sync #(.STAGES(SYNC_STAGES)) i_wr_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(wr_i), .fall_sel_i(1'b0), .edge_o(wr_evt)
  );

  cfg_edge_sync #(.STAGES(SYNC_STAGES)) i_pin_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sync_i), .fall_sel_i(pol), .edge_o(pin_evt)
  );

  cfg_reg_file #(.AW(ADDR_W), .DW(DATA_W), .GW(GAIN_W)) i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_evt_i(wr_evt), .ce_i(ce_i),
    .addr_i(addr_i), .data_i(data_i),
    .soft_rst_o(soft_rst), .time_lo_wr_o(time_lo_wr),
    .mode_o(mode_o), .gain_o(gain_o), .pol_o(pol), .timing_word_o(timing_word_o),
    .coef_we_o(coef_we_o), .coef_addr_o(coef_addr_o), .coef_data_o(coef_data_o)
  );

  cfg_sync_gen i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst), .pin_edge_i(pin_evt),
    .wr_sync_i(time_lo_wr), .run_o(run_o), .sync_o(sync_o)
  );
endmodule

// File: tb/test_cfg_sync_ctrl.sv
`timescale 1ns/1ps
module test_cfg_sync_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic        ce_i = 1'b0;
  logic [9:0]  addr_i = '0;
  logic [15:0] data_i = '0;
  logic        sync_i = 1'b0;
  logic [1:0]  mode_o;
  logic [7:0]  gain_o;
  logic [31:0] timing_word_o;
  logic        run_o, sync_o, coef_we_o;
  logic [8:0]  coef_addr_o;
  logic [15:0] coef_data_o;

  int total = 0;
  int bad = 0;
  int sync_cnt = 0;
  int long_cnt = 0;
  int coef_cnt = 0;
  logic        prev_sync = 1'b0;
  logic [8:0]  cap_addr = '0;
  logic [15:0] cap_data = '0;
  logic [7:0]  snap_pre_gain, snap_gain;
  logic        snap_pre_sync, snap_sync, snap_sync2, snap_run;

  always #4 clk_i = ~clk_i;

  cfg_sync_ctrl i_cfg_sync_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .ce_i(ce_i), .addr_i(addr_i),
    .data_i(data_i), .sync_i(sync_i), .mode_o(mode_o), .gain_o(gain_o),
    .timing_word_o(timing_word_o), .run_o(run_o), .sync_o(sync_o),
    .coef_we_o(coef_we_o), .coef_addr_o(coef_addr_o), .coef_data_o(coef_data_o)
  );

  always @(negedge clk_i) begin
    if (sync_o) sync_cnt++;
    if (sync_o && prev_sync) long_cnt++;
    prev_sync = sync_o;
    if (coef_we_o) begin
      coef_cnt++;
      cap_addr = coef_addr_o;
      cap_data = coef_data_o;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [9:0] a, input logic [15:0] d, input logic en);
    @(negedge clk_i);
    addr_i = a; data_i = d; ce_i = en; wr_i = 1'b1;
    @(posedge clk_i); @(posedge clk_i); #1;
    snap_pre_gain = gain_o; snap_pre_sync = sync_o;
    @(posedge clk_i); #1;
    snap_gain = gain_o; snap_sync = sync_o; snap_run = run_o;
    @(posedge clk_i); #1;
    snap_sync2 = sync_o;
    @(negedge clk_i);
    wr_i = 1'b0;
    repeat (3) @(negedge clk_i);
    ce_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "run", 32'(run_o), 0);
    chk("R1", "mode", 32'(mode_o), 0);
    chk("R1", "gain", 32'(gain_o), 0);
    chk("R1", "timing", timing_word_o, 0);
    chk("R1", "sync_o", 32'(sync_o), 0);
    chk("R1", "coef_we", 32'(coef_we_o), 0);
    chk("R1", "sync count", 32'(sync_cnt), 0);
  endtask

  task automatic t_latency_and_halt();
    cpu_write(10'd17, 16'h005A, 1'b1);
    chk("R11", "gain before third edge", 32'(snap_pre_gain), 0);
    chk("R4", "gain after third edge", 32'(snap_gain), 32'h5A);
    cpu_write(10'd17, 16'hFFC3, 1'b1);
    chk("R4", "gain low byte", 32'(gain_o), 32'hC3);
    chk("R5", "run still halted", 32'(run_o), 0);
  endtask

  task automatic t_ce();
    cpu_write(10'd17, 16'h0011, 1'b0);
    chk("R2", "gain with ce low", 32'(gain_o), 32'hC3);
    cpu_write(10'd600, 16'h1234, 1'b0);
    chk("R2", "no coef pulse with ce low", 32'(coef_cnt), 0);
  endtask

  task automatic t_mode();
    cpu_write(10'd16, 16'h0001, 1'b1);
    chk("R3", "mode 01", 32'(mode_o), 1);
    cpu_write(10'd16, 16'h0002, 1'b1);
    chk("R3", "mode 10", 32'(mode_o), 2);
    cpu_write(10'd16, 16'h0003, 1'b1);
    chk("R3", "mode 11 ignored", 32'(mode_o), 2);
    chk("R5", "run halted after mode writes", 32'(run_o), 0);
  endtask

  task automatic t_timing_sync();
    int c0;
    c0 = sync_cnt;
    cpu_write(10'd3, 16'hABCD, 1'b1);
    chk("R7", "high word", timing_word_o, 32'hABCD0000);
    chk("R7", "high word no sync", 32'(sync_cnt - c0), 0);
    chk("R7", "high word no run", 32'(run_o), 0);
    cpu_write(10'd2, 16'h1357, 1'b1);
    chk("R7", "low word", timing_word_o, 32'hABCD1357);
    chk("R8", "sync_o before", 32'(snap_pre_sync), 0);
    chk("R8", "sync_o pulse edge", 32'(snap_sync), 1);
    chk("R8", "sync_o next edge", 32'(snap_sync2), 0);
    chk("R8", "run at pulse", 32'(snap_run), 1);
    chk("R8", "one pulse", 32'(sync_cnt - c0), 1);
    chk("R8", "pulse width", 32'(long_cnt), 0);
  endtask

  task automatic t_soft_reset();
    cpu_write(10'd21, 16'h0000, 1'b1);
    chk("R9", "run", 32'(run_o), 0);
    chk("R9", "mode", 32'(mode_o), 0);
    chk("R9", "gain", 32'(gain_o), 0);
    chk("R9", "timing", timing_word_o, 0);
  endtask

  task automatic pin_to(input logic v);
    @(negedge clk_i);
    sync_i = v;
    repeat (6) @(negedge clk_i);
  endtask

  task automatic t_pin_rise();
    int c0;
    c0 = sync_cnt;
    pin_to(1'b1);
    chk("R6", "rise pulse pol0", 32'(sync_cnt - c0), 1);
    chk("R6", "run after rise", 32'(run_o), 1);
    pin_to(1'b0);
    chk("R6", "fall ignored pol0", 32'(sync_cnt - c0), 1);
  endtask

  task automatic t_pin_fall();
    int c0;
    cpu_write(10'd21, 16'h0000, 1'b1);
    cpu_write(10'd22, 16'h0001, 1'b1);
    c0 = sync_cnt;
    pin_to(1'b1);
    chk("R6", "rise ignored pol1", 32'(sync_cnt - c0), 0);
    chk("R6", "run stays halted pol1", 32'(run_o), 0);
    pin_to(1'b0);
    chk("R6", "fall pulse pol1", 32'(sync_cnt - c0), 1);
    chk("R6", "run after fall", 32'(run_o), 1);
    chk("R8", "pulse width pin", 32'(long_cnt), 0);
  endtask

  task automatic t_coef();
    cpu_write(10'd16, 16'h0001, 1'b1);
    cpu_write(10'd600, 16'hBEEF, 1'b1);
    chk("R10", "one coef pulse", 32'(coef_cnt), 1);
    chk("R10", "coef index", 32'(cap_addr), 88);
    chk("R10", "coef data", 32'(cap_data), 32'hBEEF);
    chk("R10", "mode untouched", 32'(mode_o), 1);
    cpu_write(10'd1023, 16'h0F0F, 1'b1);
    chk("R10", "top index", 32'(cap_addr), 511);
    chk("R10", "second pulse", 32'(coef_cnt), 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_latency_and_halt();
    t_ce();
    t_mode();
    t_timing_sync();
    t_soft_reset();
    t_pin_rise();
    t_pin_fall();
    t_coef();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule